// File: doc/BRIEF.md
# Transmit Deferral Timer

This block decides when the transmit side of a serial network port may put a new frame on the medium. It counts interframe-gap time in ticks of a serial-clock enable and raises a grant once the gap has elapsed and the transmitter is asking to send. In full-duplex operation only the gap is enforced, measured from the end of the previous transmission, and carrier sense has no effect.

In half-duplex operation the gap is split into two phases. During the first, the watch phase, carrier must stay low; any carrier activity throws the count away and the block waits for the line to go quiet again. The second, committed phase runs to completion whatever carrier does, so the grant comes exactly one full gap after the line last went quiet. The count begins at the later of the end of the previous transmission and the fall of carrier.

The grant is a level. It stays high while the request stays high and drops when the request falls or the transmission ends; the block then rearms and times a fresh gap. There is no data path, so all pins are plain control signals with no valid/ready handshake.

Top module: `tx_defer_timer`

## Requirements
- R1: With `full_duplex` high, and `tx_req` high, `tx_grant` rises at the clock edge that samples the 96th `sclk_en` tick after reset, `tx_done` or a grant release, whatever `crs` does.
- R2: With `full_duplex` low, ticks are counted only while `crs` is low. The first 60 ticks form the watch phase and the next 36 the committed phase. With `tx_req` high, `tx_grant` rises at the edge that samples the 96th tick.
- R3: In half-duplex mode, `crs` high on any cycle of the watch phase clears the count, so a full 96 quiet ticks are needed again once `crs` falls.
- R4: In half-duplex mode, `crs` during the committed phase has no effect; the grant arrives on the same edge as with `crs` low.
- R5: A `tx_done` pulse clears the count on the next edge from any state. In half-duplex mode, counting resumes only when `crs` is also low, so the gap runs from the later of the two events.
- R6: Cycles with `sclk_en` low never advance the count.
- R7: `tx_grant` rises only while `tx_req` is high. It stays high while `tx_req` stays high and falls on the edge after `tx_req` is sampled low. A new grant then needs a fresh 96-tick gap.
- R8: Once the gap is complete with `tx_req` low, the block waits. `tx_grant` rises on the edge that first samples `tx_req` high. In half-duplex mode, `crs` high while the block waits without a request sends it back to the watch phase with the count cleared.
- R9: A synchronous `rst` drives `tx_grant` low on the next edge and clears the count.
- R10: `tx_done` takes priority over `tx_req`. It drops a held grant on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_en | input | 1 | One-cycle enable marking each serial-clock tick |
| crs | input | 1 | Carrier sense from the physical layer |
| full_duplex | input | 1 | 1 selects full duplex, 0 selects half duplex; held static while running |
| tx_req | input | 1 | Transmitter wants to start a frame |
| tx_done | input | 1 | One-cycle pulse at the end of the previous transmission |
| tx_grant | output | 1 | Frame may start; held until `tx_req` falls or `tx_done` pulses |

## Verification
Every result is a single register stage away from the inputs that cause it. A grant is visible the cycle after the edge that samples the final tick, or the request in the waiting state. A release, `tx_done` or reset clears the grant after one edge. The bench drives inputs on the falling clock edge. A behavioural model updates on the same rising edge as the design and is compared on the next falling edge, so every result is checked in the cycle it becomes due. Scenarios place carrier pulses at chosen tick counts on both sides of the 60-tick boundary, thin out `sclk_en`, and release or end a grant, so that each timing edge is checked to the exact cycle.

// File: rtl/tx_defer_pkg.sv
package tx_defer_pkg;

  typedef enum logic [1:0] {
    PH_WATCH  = 2'd0,
    PH_COMMIT = 2'd1,
    PH_READY  = 2'd2,
    PH_GRANT  = 2'd3
  } defer_phase_e;

endpackage

// File: rtl/tx_defer_tick_counter.sv
module tx_defer_tick_counter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          at_last
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == limit - 1'b1);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    !clr && inc |=> cnt != '0) else $error("tick counter wrapped"); // R6

endmodule

// File: rtl/tx_defer_carrier_qual.sv
module tx_defer_carrier_qual (
  input  logic crs,
  input  logic full_duplex,
  output logic carrier_blocks
);

  // Carrier only matters when the medium is shared.
  assign carrier_blocks = crs && !full_duplex;

endmodule

// File: rtl/tx_defer_fsm.sv
module tx_defer_fsm
  import tx_defer_pkg::*;
#(
  parameter int WATCH_TICKS  = 60,
  parameter int COMMIT_TICKS = 36,
  parameter int CW           = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_en,
  input  logic          carrier_blocks,
  input  logic          tx_req,
  input  logic          tx_done,
  input  logic          at_last,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic [CW-1:0] cnt_limit,
  output logic          tx_grant
);

  localparam logic [CW-1:0] WATCH_LIM  = CW'(WATCH_TICKS);
  localparam logic [CW-1:0] COMMIT_LIM = CW'(COMMIT_TICKS);

  defer_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (tx_done) begin
      phase_d = PH_WATCH;
      cnt_clr = 1'b1;
    end else begin
      unique case (phase_q)
        PH_WATCH: begin
          if (carrier_blocks) begin
            cnt_clr = 1'b1;
          end else if (sclk_en) begin
            if (at_last) begin
              phase_d = PH_COMMIT;
              cnt_clr = 1'b1;
            end else begin
              cnt_inc = 1'b1;
            end
          end
        end
        PH_COMMIT: begin
          if (sclk_en) begin
            if (at_last) begin
              phase_d = tx_req ? PH_GRANT : PH_READY;
              cnt_clr = 1'b1;
            end else begin
              cnt_inc = 1'b1;
            end
          end
        end
        PH_READY: begin
          if (tx_req) begin
            phase_d = PH_GRANT;
          end else if (carrier_blocks) begin
            phase_d = PH_WATCH;
            cnt_clr = 1'b1;
          end
        end
        PH_GRANT: begin
          if (!tx_req) begin
            phase_d = PH_WATCH;
            cnt_clr = 1'b1;
          end
        end
        default: begin
          phase_d = PH_WATCH;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_WATCH;
    else     phase_q <= phase_d;
  end

  assign cnt_limit = (phase_q == PH_COMMIT) ? COMMIT_LIM : WATCH_LIM;
  assign tx_grant  = (phase_q == PH_GRANT);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!tx_grant && cnt == '0)) else $error("reset left state"); // R9

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_grant) |-> $past(tx_req)) else $error("grant without request"); // R7

  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (tx_grant && !tx_req) |=> !tx_grant) else $error("grant held after release"); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> (!tx_grant && cnt == '0)) else $error("done did not clear"); // R10

  AST_CARRIER_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WATCH && carrier_blocks) |=> cnt == '0) else $error("carrier kept count"); // R3

  AST_COMMIT_IGNORES_CRS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_COMMIT && !tx_done) |=> phase_q != PH_WATCH) else $error("commit phase abandoned"); // R4

  AST_NO_TICK_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!sclk_en && !tx_done && (phase_q == PH_WATCH || phase_q == PH_COMMIT) && cnt != '0)
      |=> (cnt == $past(cnt) || cnt == '0)) else $error("count moved without tick"); // R6

endmodule

// File: rtl/tx_defer_timer.sv
module tx_defer_timer #(
  parameter int WATCH_TICKS  = 60,
  parameter int COMMIT_TICKS = 36
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_en,
  input  logic crs,
  input  logic full_duplex,
  input  logic tx_req,
  input  logic tx_done,
  output logic tx_grant
);

  localparam int MAX_TICKS = (WATCH_TICKS > COMMIT_TICKS) ? WATCH_TICKS : COMMIT_TICKS;
  localparam int CW        = $clog2(MAX_TICKS + 1);

  logic          carrier_blocks;
  logic          cnt_clr;
  logic          cnt_inc;
  logic          at_last;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_limit;

  tx_defer_carrier_qual u_qual (
    .crs            (crs),
    .full_duplex    (full_duplex),
    .carrier_blocks (carrier_blocks)
  );

  tx_defer_tick_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .limit   (cnt_limit),
    .cnt     (cnt),
    .at_last (at_last)
  );

  tx_defer_fsm #(
    .WATCH_TICKS  (WATCH_TICKS),
    .COMMIT_TICKS (COMMIT_TICKS),
    .CW           (CW)
  ) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .sclk_en        (sclk_en),
    .carrier_blocks (carrier_blocks),
    .tx_req         (tx_req),
    .tx_done        (tx_done),
    .at_last        (at_last),
    .cnt            (cnt),
    .cnt_clr        (cnt_clr),
    .cnt_inc        (cnt_inc),
    .cnt_limit      (cnt_limit),
    .tx_grant       (tx_grant)
  );

  AST_FD_GRANT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (full_duplex && $rose(tx_grant)) |-> !$past(tx_done)) else $error("grant right after done"); // R1

endmodule

// File: tb/tx_defer_timer_test.sv
`timescale 1ns/1ps
module tx_defer_timer_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_en = 1'b0;
  logic crs = 1'b0;
  logic full_duplex = 1'b1;
  logic tx_req = 1'b0;
  logic tx_done = 1'b0;
  logic tx_grant;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int en_div = 1;
  string cur_req = "R9";

  // Reference model state
  int  m_ticks = 0;
  bit  m_grant = 1'b0;

  always #10 clk = ~clk;

  tx_defer_timer uut (
    .clk (clk), .rst (rst), .sclk_en (sclk_en), .crs (crs),
    .full_duplex (full_duplex), .tx_req (tx_req), .tx_done (tx_done),
    .tx_grant (tx_grant)
  );

  // Behavioural model: one integer of quiet ticks since the last restart.
  always @(posedge clk) begin
    cyc++;
    if (rst || tx_done) begin
      m_ticks = 0; m_grant = 1'b0;
    end else if (m_grant) begin
      if (!tx_req) begin m_grant = 1'b0; m_ticks = 0; end
    end else if (m_ticks >= 96) begin
      if (tx_req) m_grant = 1'b1;
      else if (!full_duplex && crs) m_ticks = 0;
    end else if (m_ticks < 60 && !full_duplex && crs) begin
      m_ticks = 0;
    end else if (sclk_en) begin
      m_ticks++;
      if (m_ticks == 96 && tx_req) m_grant = 1'b1;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (tx_grant !== m_grant) begin
      errors++;
      $display("FAIL %s cycle %0d: tx_grant=%0b expected %0b", cur_req, cyc, tx_grant, m_grant);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_done = 1'b0;
      sclk_en = (en_div <= 1) ? 1'b1 : ((cyc % en_div) == 0);
    end
  endtask

  task automatic pulse_done();
    @(negedge clk);
    tx_done = 1'b1;
    sclk_en = (en_div <= 1) ? 1'b1 : ((cyc % en_div) == 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    summary();
  end

  initial begin
    // R9 reset state
    cur_req = "R9";
    step(3);
    rst = 1'b0;
    // R1 full duplex, carrier held high is ignored
    cur_req = "R1";
    full_duplex = 1'b1; crs = 1'b1; tx_req = 1'b1;
    step(110);
    // R7 release and re-request needs a fresh gap
    cur_req = "R7";
    tx_req = 1'b0; step(5);
    tx_req = 1'b1; step(50);
    if (tx_grant !== 1'b0) begin errors++; $display("FAIL R7: grant=%0b expected 0 mid-gap", tx_grant); end
    checks++;
    step(60);
    // R10 done while granted
    cur_req = "R10";
    pulse_done(); step(100);
    tx_req = 1'b0; step(3);
    // R2 half duplex, carrier busy then quiet
    cur_req = "R2";
    full_duplex = 1'b0; crs = 1'b1; pulse_done(); tx_req = 1'b1;
    step(20); crs = 1'b0; step(110);
    tx_req = 1'b0; step(2);
    // R3 carrier inside watch phase
    cur_req = "R3";
    tx_req = 1'b1; step(30); crs = 1'b1; step(2); crs = 1'b0; step(70);
    if (tx_grant !== 1'b0) begin errors++; $display("FAIL R3: grant=%0b expected 0 after restart", tx_grant); end
    checks++;
    step(40);
    tx_req = 1'b0; step(2);
    // R4 carrier inside committed phase
    cur_req = "R4";
    tx_req = 1'b1; step(70); crs = 1'b1; step(10); crs = 1'b0; step(20);
    tx_req = 1'b0; step(2);
    // R5 done arriving while carrier quiet restarts, then carrier later
    cur_req = "R5";
    tx_req = 1'b1; step(40); pulse_done(); step(50); crs = 1'b1; step(4);
    pulse_done(); step(6); crs = 1'b0; step(100);
    tx_req = 1'b0; step(2);
    // R6 sparse serial ticks
    cur_req = "R6";
    en_div = 3; tx_req = 1'b1; step(310);
    tx_req = 1'b0; step(2);
    en_div = 1;
    // R8 gap complete without request, then carrier, then request
    cur_req = "R8";
    step(110); crs = 1'b1; step(3); crs = 1'b0; step(20);
    tx_req = 1'b1; step(100);
    tx_req = 1'b0; step(100); tx_req = 1'b1; step(4);
    tx_req = 1'b0; step(2);
    // R9 reset mid-count
    cur_req = "R9";
    tx_req = 1'b1; step(50); rst = 1'b1; step(2); rst = 1'b0; step(100);
    summary();
  end

endmodule